// File: doc/BRIEF.md
# Pointer-Indexed Open-Drain Port Controller

This block controls an eight-line bidirectional port whose lines are reached one at a time. An index register names the line, and a command strobe then acts on that one line. A set command raises the line's latch so that the line floats. A clear command lowers the latch so that the line is pulled low. A release command floats every line at once. A test command samples the line and raises a skip flag when the line reads low.

Every line is open-drain, so the block can only pull a line low. Its outputs are per-line pull-low enables. It reads the line levels back through a separate input, and a line can only carry an external signal while its latch is 1.

The two highest lines can be given to a timer counter. While a line's counter-mode bit is 1, the counter's pull-low request drives that line. The line's latch is kept, and it takes effect again when port mode returns.

Top module: `opd_port_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, all latches are 1, `drive_low` is all zeros and `skip` is 0.
- R2: When `idx_we` is 1 at a rising edge, `idx_wdata` is loaded into the index register. A command presented in that same cycle uses the index held before the edge.
- R3: The command `cmd` = 3'd1 (set), with an index below 8, writes 1 into the selected latch. From the next cycle that line's `drive_low` bit is 0.
- R4: The command `cmd` = 3'd2 (clear), with an index below 8, writes 0 into the selected latch. From the next cycle that line's `drive_low` bit is 1. No other latch changes.
- R5: The command `cmd` = 3'd3 (release all) writes 1 into all eight latches, whatever the index holds.
- R6: The command `cmd` = 3'd4 (test), with an index below 8 and `pin_in` at that index equal to 0, makes `skip` 1 for exactly the one cycle after the command.
- R7: A test whose selected `pin_in` bit is 1 leaves `skip` at 0. `skip` is never 1 in a cycle that does not follow a test.
- R8: A set or clear command with an index of 8 or more changes no latch.
- R9: A test command with an index of 8 or more leaves `skip` at 0.
- R10: While `cnt_mode[0]` is 1, `drive_low[6]` equals `cnt_drive_low[0]`. While `cnt_mode[1]` is 1, `drive_low[7]` equals `cnt_drive_low[1]`.
- R11: In counter mode the latch of line 6 or 7 still obeys set and clear. It drives the line again as soon as that line's `cnt_mode` bit returns to 0.
- R12: Command codes 3'd0, 3'd5, 3'd6 and 3'd7 change no latch and raise no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Load strobe for the index register |
| idx_wdata | input | 4 | New index value |
| cmd | input | 3 | Command code: 0 none, 1 set, 2 clear, 3 release all, 4 test, 5-7 none |
| pin_in | input | 8 | Levels read back from the lines |
| cnt_mode | input | 2 | Counter-mode bits for lines 6 and 7 |
| cnt_drive_low | input | 2 | Counter pull-low requests for lines 6 and 7 |
| drive_low | output | 8 | Per-line pull-low enable |
| skip | output | 1 | One-cycle skip request after a test that read low |

## Verification
The bench builds the block with its default parameters: eight lines, a four-bit index and two counter-shared lines. With these values the index can reach 8 through 15, so the out-of-range handling of set, clear and test can be tested at the ports. The shared lines sit at indices 6 and 7, so line 5 serves as an unshared neighbour that counter mode must leave alone. The bench models the wired lines as external level AND NOT `drive_low`. This lets a test on a line that the block pulls low read low, as the open-drain requirement says it must.

// File: rtl/opd_pkg.sv
package opd_pkg;

    typedef enum logic [2:0] {
        OPC_NONE   = 3'd0,
        OPC_SET    = 3'd1,
        OPC_CLR    = 3'd2,
        OPC_RELALL = 3'd3,
        OPC_TEST   = 3'd4
    } opc_e;

    typedef struct packed {
        logic set_one;
        logic clr_one;
        logic rel_all;
        logic test_one;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic [2:0] code);
        cmd_dec_t d;
        d = '0;
        case (code)
            OPC_SET:    d.set_one  = 1'b1;
            OPC_CLR:    d.clr_one  = 1'b1;
            OPC_RELALL: d.rel_all  = 1'b1;
            OPC_TEST:   d.test_one = 1'b1;
            default:    d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/opd_index_dec.sv
module opd_index_dec #(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idx_we,
    input  logic [IDX_W-1:0]    idx_wdata,
    output logic [NUM_PINS-1:0] sel_onehot,
    output logic                idx_valid
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= idx_wdata;
        end
    end

    always_comb begin
        idx_valid = (32'(idx_q) < NUM_PINS);
        for (int i = 0; i < NUM_PINS; i++) begin
            sel_onehot[i] = idx_valid && (32'(idx_q) == i);
        end
    end

    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot));
    p_invalid_no_sel_r8: assert property (@(posedge clk) disable iff (rst)
        !idx_valid |-> (sel_onehot == '0));
endmodule

// File: rtl/opd_latch_bank.sv
module opd_latch_bank
    import opd_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_dec_t            dec,
    input  logic [NUM_PINS-1:0] sel_onehot,
    output logic [NUM_PINS-1:0] latch_q
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                latch_q[i] <= 1'b1;
            end else if (dec.rel_all) begin
                latch_q[i] <= 1'b1;
            end else if (dec.set_one && sel_onehot[i]) begin
                latch_q[i] <= 1'b1;
            end else if (dec.clr_one && sel_onehot[i]) begin
                latch_q[i] <= 1'b0;
            end
        end
    end

    p_set_hits_r3: assert property (@(posedge clk) disable iff (rst)
        dec.set_one |=> ((latch_q & $past(sel_onehot)) == $past(sel_onehot)));
    p_clr_hits_r4: assert property (@(posedge clk) disable iff (rst)
        dec.clr_one |=> ((latch_q & $past(sel_onehot)) == '0));
    p_relall_r5: assert property (@(posedge clk) disable iff (rst)
        dec.rel_all |=> (latch_q == '1));
    p_oor_stable_r8: assert property (@(posedge clk) disable iff (rst)
        ((dec.set_one || dec.clr_one) && sel_onehot == '0) |=> $stable(latch_q));
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (dec == '0) |=> $stable(latch_q));
endmodule

// File: rtl/opd_skip_unit.sv
module opd_skip_unit
    import opd_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_dec_t            dec,
    input  logic [NUM_PINS-1:0] sel_onehot,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic                skip_q
);
    logic sel_reads_low;

    assign sel_reads_low = (sel_onehot != '0) && ((pin_in & sel_onehot) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_q <= 1'b0;
        end else begin
            skip_q <= dec.test_one && sel_reads_low;
        end
    end

    p_skip_only_after_test_r7: assert property (@(posedge clk) disable iff (rst)
        !dec.test_one |=> !skip_q);
    p_oor_no_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (dec.test_one && sel_onehot == '0) |=> !skip_q);
endmodule

// File: rtl/opd_pin_mux.sv
module opd_pin_mux #(
    parameter int NUM_PINS   = 8,
    parameter int NUM_SHARED = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PINS-1:0]   latch_q,
    input  logic [NUM_SHARED-1:0] cnt_mode,
    input  logic [NUM_SHARED-1:0] cnt_drive_low,
    output logic [NUM_PINS-1:0]   drive_low
);
    localparam int SHARED_BASE = NUM_PINS - NUM_SHARED;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        if (i >= SHARED_BASE) begin : g_shared
            assign drive_low[i] = cnt_mode[i-SHARED_BASE]
                                ? cnt_drive_low[i-SHARED_BASE]
                                : ~latch_q[i];
        end else begin : g_plain
            assign drive_low[i] = ~latch_q[i];
        end
    end

    p_plain_unaffected_r10: assert property (@(posedge clk) disable iff (rst)
        ($stable(latch_q) && $stable(cnt_drive_low))
            |-> $stable(drive_low[SHARED_BASE-1:0]));
endmodule

// File: rtl/opd_port_ctrl.sv
module opd_port_ctrl
    import opd_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int IDX_W      = 4,
    parameter int NUM_SHARED = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  idx_we,
    input  logic [IDX_W-1:0]      idx_wdata,
    input  logic [2:0]            cmd,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [NUM_SHARED-1:0] cnt_mode,
    input  logic [NUM_SHARED-1:0] cnt_drive_low,
    output logic [NUM_PINS-1:0]   drive_low,
    output logic                  skip
);
    cmd_dec_t            dec;
    logic [NUM_PINS-1:0] sel_onehot;
    logic                idx_valid;
    logic [NUM_PINS-1:0] latch_q;

    assign dec = decode_cmd(cmd);

    opd_index_dec #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst(rst), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .sel_onehot(sel_onehot), .idx_valid(idx_valid)
    );

    opd_latch_bank #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk(clk), .rst(rst), .dec(dec), .sel_onehot(sel_onehot), .latch_q(latch_q)
    );

    opd_skip_unit #(.NUM_PINS(NUM_PINS)) u_skip (
        .clk(clk), .rst(rst), .dec(dec), .sel_onehot(sel_onehot),
        .pin_in(pin_in), .skip_q(skip)
    );

    opd_pin_mux #(.NUM_PINS(NUM_PINS), .NUM_SHARED(NUM_SHARED)) u_mux (
        .clk(clk), .rst(rst), .latch_q(latch_q), .cnt_mode(cnt_mode),
        .cnt_drive_low(cnt_drive_low), .drive_low(drive_low)
    );

    p_reset_released_r1: assert property (@(posedge clk)
        $past(rst) |-> (latch_q == '1 && !skip));
    p_skip_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        skip |=> !skip || $past(dec.test_one));
    p_dec_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec));
    p_idx_valid_match_r2: assert property (@(posedge clk) disable iff (rst)
        idx_valid == (sel_onehot != '0));
endmodule

// File: tb/opd_port_ctrl_tb_top.sv
module opd_port_ctrl_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic       idx_we = 0;
    logic [3:0] idx_wdata = 0;
    logic [2:0] cmd = 0;
    logic [7:0] ext_lvl = 8'hFF;
    logic [7:0] pin_in;
    logic [1:0] cnt_mode = 0;
    logic [1:0] cnt_drive_low = 0;
    logic [7:0] drive_low;
    logic       skip;
    int checks = 0;
    int errors = 0;
    logic [7:0] exp_latch;

    always #4 clk = ~clk;

    assign pin_in = ext_lvl & ~drive_low;

    opd_port_ctrl dut_i (
        .clk(clk), .rst(rst), .idx_we(idx_we), .idx_wdata(idx_wdata), .cmd(cmd),
        .pin_in(pin_in), .cnt_mode(cnt_mode), .cnt_drive_low(cnt_drive_low),
        .drive_low(drive_low), .skip(skip)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic setidx(input logic [3:0] v);
        @(negedge clk); idx_we = 1; idx_wdata = v; cmd = 0;
        step(); @(negedge clk); idx_we = 0;
    endtask

    task automatic issue(input logic [2:0] c);
        @(negedge clk); cmd = c;
        step(); @(negedge clk); cmd = 0;
    endtask

    task automatic t_reset;
        rst = 1; repeat (3) step(); @(negedge clk); rst = 0; step();
        exp_latch = 8'hFF;
        chk("R1 drive_low", drive_low, 8'h00);
        chk("R1 skip", {7'b0, skip}, 8'h00);
    endtask

    task automatic t_set_clear;
        for (int i = 0; i < 6; i++) begin
            setidx(4'(i)); issue(3'd2); exp_latch[i] = 0;
            chk("R4 clear", drive_low, ~exp_latch);
        end
        setidx(4'd3); issue(3'd1); exp_latch[3] = 1;
        chk("R3 set", drive_low, ~exp_latch);
    endtask

    task automatic t_same_cycle_idx;
        setidx(4'd0);
        @(negedge clk); idx_we = 1; idx_wdata = 4'd1; cmd = 3'd1;
        step(); @(negedge clk); idx_we = 0; cmd = 0;
        exp_latch[0] = 1;
        chk("R2 old index used", drive_low, ~exp_latch);
        issue(3'd1); exp_latch[1] = 1;
        chk("R2 new index", drive_low, ~exp_latch);
    endtask

    task automatic t_oor;
        setidx(4'd9); issue(3'd1); chk("R8 set oor", drive_low, ~exp_latch);
        issue(3'd2); chk("R8 clr oor", drive_low, ~exp_latch);
        ext_lvl = 8'h00;
        issue(3'd4); chk("R9 test oor", {7'b0, skip}, 8'h00);
        ext_lvl = 8'hFF;
    endtask

    task automatic t_noop_codes;
        for (int c = 5; c < 8; c++) begin
            setidx(4'd4); issue(3'(c));
            chk("R12 latch", drive_low, ~exp_latch);
            chk("R12 skip", {7'b0, skip}, 8'h00);
        end
        issue(3'd0); chk("R12 none", drive_low, ~exp_latch);
    endtask

    task automatic t_test;
        setidx(4'd4);
        @(negedge clk); cmd = 3'd4; step();
        chk("R6 skip pulse (driven low)", {7'b0, skip}, 8'h01);
        @(negedge clk); cmd = 0; step();
        chk("R6 skip one cycle", {7'b0, skip}, 8'h00);
        setidx(4'd6); issue(3'd4); chk("R7 high no skip", {7'b0, skip}, 8'h00);
        ext_lvl[6] = 0;
        @(negedge clk); cmd = 3'd4; step();
        chk("R6 external low", {7'b0, skip}, 8'h01);
        @(negedge clk); cmd = 0; ext_lvl = 8'hFF;
    endtask

    task automatic t_counter;
        @(negedge clk); cnt_mode = 2'b01; cnt_drive_low = 2'b01; #1;
        chk("R10 pin6 counter", drive_low, {~exp_latch[7], 1'b1, ~exp_latch[5:0]});
        @(negedge clk); cnt_mode = 2'b11; cnt_drive_low = 2'b10; #1;
        chk("R10 both counter", drive_low, {2'b10, ~exp_latch[5:0]});
        setidx(4'd7); issue(3'd2); exp_latch[7] = 0;
        chk("R11 latch hidden", drive_low, {2'b10, ~exp_latch[5:0]});
        @(negedge clk); cnt_mode = 2'b00; #1;
        chk("R11 latch reapplied", drive_low, ~exp_latch);
    endtask

    task automatic t_relall;
        setidx(4'd12); issue(3'd3); exp_latch = 8'hFF;
        chk("R5 release all", drive_low, 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_set_clear(); t_same_cycle_idx(); t_oor();
                t_noop_codes(); t_test(); t_counter(); t_relall();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule